// File: doc/BRIEF.md
# Protected Paged EEPROM Write Controller

This block is the write front end for a small non-volatile byte array that is organised as fixed-size pages. A producer streams data bytes in over a valid/ready interface. The first beat of a transfer carries the start address. Every beat is staged in a one-page buffer. The beat marked `wr_last` closes the transfer, and the staged bytes are then committed to the array, one page slot per cycle.

A 3-bit protection code is applied to each byte as it is committed. The code selects either an upper-anchored or a lower-anchored address range. A byte that falls inside the selected range is dropped without any error indication. A read port returns the stored contents one cycle after an address is presented.

Back-pressure rules: a beat is taken on any rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low for the whole commit. While it is low, the producer must hold its beat and nothing is captured. The producer may present a beat at any other time.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `busy` is 0, `wr_ready` is 1, every array byte reads 0 and `rd_data` is 0.
- R2: On the first accepted beat of a transfer, `wr_addr[8:4]` selects the page for the whole transfer and `wr_addr[3:0]` selects the slot for that first byte.
- R3: Each later beat of the same transfer goes to the next slot. The slot is the low 4 bits and wraps from 15 to 0 inside the same page. The page bits never change.
- R4: When a transfer carries more than 16 bytes, a later byte replaces the earlier byte staged in the same wrapped slot. Only the last byte per slot is stored.
- R5: A single-beat transfer (the first beat also has `wr_last`=1) changes exactly one byte.
- R6: Protection codes 3'b001 and 3'b010 block addresses 0x180..0x1FF and 0x100..0x1FF respectively. Addresses just below each range are still written.
- R7: Protection codes 3'b100, 3'b101 and 3'b110 block addresses 0x000..0x03F, 0x000..0x07F and 0x000..0x0FF respectively. Addresses just above each range are still written.
- R8: Codes 3'b011 and 3'b111 block the whole array. Code 3'b000 blocks nothing.
- R9: A write to a blocked address leaves that byte unchanged and raises no error.
- R10: `busy` rises in the cycle after the `wr_last` beat is accepted, stays high for exactly 16 cycles and then falls.
- R11: `wr_ready` is low exactly while `busy` is high. A beat offered during that time is not captured.
- R12: `rd_data` shows the array byte at `rd_addr` as it stood just before the rising edge that samples `rd_addr`.
- R13: Slots of the page that no beat of the transfer reached keep their previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_code | input | 3 | Protection range selector, applied at commit |
| wr_valid | input | 1 | A data beat is offered |
| wr_ready | output | 1 | The block can take a beat |
| wr_addr | input | 9 | Start address, used on the first beat of a transfer |
| wr_data | input | 8 | Data byte |
| wr_last | input | 1 | Final beat of the transfer |
| busy | output | 1 | Commit in progress |
| rd_addr | input | 9 | Read address |
| rd_data | output | 8 | Registered read data |

## Verification
The bench targets these corner cases:

- A start offset near the page end. A design that carried into the page bits would spill bytes into the next page instead of wrapping to slot 0.
- An 18-byte transfer. A design that dropped the overflow bytes, or stopped at 16, would keep the first bytes in slots 0 and 1 instead of the later ones.
- Each protection code, with one byte written on each side of its range boundary. A wrong decode shows up as a byte that changes when it should not, or stays 0 when it should change.
- Beats offered during the commit. A design that accepted them would write a byte that must stay 0, and a commit window off by one cycle breaks the per-cycle comparison of `busy`.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  localparam int DEF_ADDR_W = 9;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_OFFS_W = 4;

  typedef enum logic [2:0] {
    PROT_OPEN    = 3'd0,
    PROT_TOP_QTR = 3'd1,
    PROT_TOP_HLF = 3'd2,
    PROT_ALL_A   = 3'd3,
    PROT_LOW_4P  = 3'd4,
    PROT_LOW_8P  = 3'd5,
    PROT_LOW_16P = 3'd6,
    PROT_ALL_B   = 3'd7
  } prot_e;
endpackage

// File: rtl/eepw_prot_decode.sv
module eepw_prot_decode
  import eepw_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int OFFS_W = DEF_OFFS_W
) (
  input  logic [2:0]        code,
  input  logic [ADDR_W-1:0] addr,
  output logic              blocked
);
  localparam int N_LOW = 3;

  // low_hit[k]: address lies within the first 4<<k pages
  logic [N_LOW-1:0] low_hit;
  for (genvar k = 0; k < N_LOW; k++) begin : g_low
    localparam int SPAN_W = OFFS_W + 2 + k;
    assign low_hit[k] = (addr[ADDR_W-1:SPAN_W] == '0);
  end

  logic top_half, top_qtr;
  assign top_half = addr[ADDR_W-1];
  assign top_qtr  = &addr[ADDR_W-1:ADDR_W-2];

  always_comb begin
    unique case (prot_e'(code))
      PROT_OPEN:    blocked = 1'b0;
      PROT_TOP_QTR: blocked = top_qtr;
      PROT_TOP_HLF: blocked = top_half;
      PROT_LOW_4P:  blocked = low_hit[0];
      PROT_LOW_8P:  blocked = low_hit[1];
      PROT_LOW_16P: blocked = low_hit[2];
      default:      blocked = 1'b1;
    endcase
  end
endmodule

// File: rtl/eepw_page_buffer.sv
module eepw_page_buffer
  import eepw_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int OFFS_W = DEF_OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              put,
  input  logic [OFFS_W-1:0] put_slot,
  input  logic [DATA_W-1:0] put_data,
  input  logic              clear,
  input  logic [OFFS_W-1:0] get_slot,
  output logic [DATA_W-1:0] get_data,
  output logic              get_full
);
  localparam int SLOTS = 1 << OFFS_W;

  logic [DATA_W-1:0] store [SLOTS];
  logic [SLOTS-1:0]  filled;

  always_ff @(posedge clk) begin
    if (put) store[put_slot] <= put_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     filled <= '0;
    else if (clear) filled <= '0;
    else if (put)   filled[put_slot] <= 1'b1;
  end

  assign get_data = store[get_slot];
  assign get_full = filled[get_slot];
endmodule

// File: rtl/eepw_mem_array.sv
module eepw_mem_array
  import eepw_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      rdata <= '0;
    end else begin
      rdata <= cells[raddr];
      if (we) cells[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eepw_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int OFFS_W = DEF_OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        prot_code,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  output logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAGE_W = ADDR_W - OFFS_W;
  localparam logic [OFFS_W-1:0] LAST_SLOT = '1;

  logic              in_xfer;
  logic [PAGE_W-1:0] page_q;
  logic [OFFS_W-1:0] ptr_q, cslot_q, put_slot;
  logic              take, commit_end;
  logic [DATA_W-1:0] buf_data;
  logic              buf_full, blocked;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;

  assign wr_ready   = ~busy;
  assign take       = wr_valid & wr_ready;
  assign put_slot   = in_xfer ? ptr_q : wr_addr[OFFS_W-1:0];
  assign commit_end = busy & (cslot_q == LAST_SLOT);
  assign mem_waddr  = {page_q, cslot_q};
  assign mem_we     = busy & buf_full & ~blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_xfer <= 1'b0;
      page_q  <= '0;
      ptr_q   <= '0;
      cslot_q <= '0;
      busy    <= 1'b0;
    end else if (busy) begin
      cslot_q <= cslot_q + 1'b1;
      if (commit_end) busy <= 1'b0;
    end else if (take) begin
      if (!in_xfer) page_q <= wr_addr[ADDR_W-1:OFFS_W];
      ptr_q   <= put_slot + 1'b1;
      in_xfer <= ~wr_last;
      if (wr_last) begin
        busy    <= 1'b1;
        cslot_q <= '0;
      end
    end
  end

  eepw_page_buffer #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .put      (take),
    .put_slot (put_slot),
    .put_data (wr_data),
    .clear    (commit_end),
    .get_slot (cslot_q),
    .get_data (buf_data),
    .get_full (buf_full)
  );

  eepw_prot_decode #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_prot (
    .code    (prot_code),
    .addr    (mem_waddr),
    .blocked (blocked)
  );

  eepw_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (buf_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/eepw_checker.sv
module eepw_checker #(
  parameter int ADDR_W = 9,
  parameter int OFFS_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        prot_code,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              wr_last,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << OFFS_W;
  localparam int SLOTS = PAGE;

  logic [7:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 8'd1;
    else           busy_cnt <= '0;
  end

  function automatic logic in_range(input logic [2:0] c, input int a);
    case (c)
      3'd0: return 1'b0;
      3'd1: return a >= (DEPTH * 3) / 4;
      3'd2: return a >= DEPTH / 2;
      3'd4: return a < 4 * PAGE;
      3'd5: return a < 8 * PAGE;
      3'd6: return a < 16 * PAGE;
      default: return 1'b1;
    endcase
  endfunction

  p_busy_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_last) |=> busy);

  p_busy_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(busy_cnt) == 8'(SLOTS - 1)));

  p_busy_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt < 8'(SLOTS)));

  p_write_only_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  p_no_blocked_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !in_range(prot_code, int'(mem_waddr)));
endmodule

bind eeprom_page_writer eepw_checker #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .prot_code (prot_code),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_last   (wr_last),
  .busy      (busy),
  .mem_we    (mem_we),
  .mem_waddr (mem_waddr)
);

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] prot_code = 3'd0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [8:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wr_last = 1'b0;
  logic       busy;
  logic [8:0] rd_addr = '0;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  eeprom_page_writer i_eeprom_page_writer (
    .clk(clk), .rst_n(rst_n), .prot_code(prot_code),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_last(wr_last), .busy(busy),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // behavioural reference model
  int m_mem [512];
  int m_stage [int];
  int m_base, m_pos, m_left, m_rd;
  bit m_open, m_busy;

  function automatic bit m_blocked(int code, int a);
    int lo, hi;
    lo = 0; hi = -1;
    case (code)
      1: begin lo = 384; hi = 511; end
      2: begin lo = 256; hi = 511; end
      3, 7: begin lo = 0; hi = 511; end
      4: hi = 63;
      5: hi = 127;
      6: hi = 255;
      default: hi = -1;
    endcase
    return (a >= lo) && (a <= hi);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_stage.delete();
      m_open = 0; m_busy = 0; m_left = 0; m_rd = 0;
    end else begin
      m_rd = m_mem[rd_addr];
      if (m_busy) begin
        int slot;
        slot = 16 - m_left;
        if (m_stage.exists(slot) && !m_blocked(prot_code, m_base + slot))
          m_mem[m_base + slot] = m_stage[slot];
        m_left--;
        if (m_left == 0) begin
          m_busy = 0;
          m_stage.delete();
        end
      end else if (wr_valid) begin
        if (!m_open) begin
          m_base = (wr_addr / 16) * 16;
          m_pos = wr_addr % 16;
        end
        m_stage[m_pos] = wr_data;
        m_pos = (m_pos + 1) % 16;
        m_open = !wr_last;
        if (wr_last) begin
          m_busy = 1;
          m_left = 16;
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10 busy", busy, m_busy);
      check("R11 wr_ready", wr_ready, !m_busy);
      check("R12 rd_data", rd_data, m_rd);
    end
  end

  task automatic send(input logic [8:0] a, input int n, input logic [7:0] d0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!wr_ready) @(negedge clk);
      wr_valid = 1'b1;
      wr_addr  = a;
      wr_data  = d0 + 8'(i);
      wr_last  = (i == n - 1);
    end
    @(negedge clk);
    wr_valid = 1'b0;
    wr_last  = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic peek(input logic [8:0] a, input int exp, input string req);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    check(req, rd_data, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy at reset", busy, 0);
    check("R1 ready at reset", wr_ready, 1);
    peek(9'h000, 0, "R1 array cleared");
    peek(9'h1FF, 0, "R1 array cleared");

    // R2, R3, R13: mid-page start, 8 bytes
    send(9'h025, 8, 8'hA0);
    peek(9'h025, 8'hA0, "R2 first slot");
    peek(9'h02C, 8'hA7, "R3 last slot");
    peek(9'h024, 0, "R13 untouched below");
    peek(9'h02D, 0, "R13 untouched above");

    // R3: wrap inside page
    send(9'h03E, 3, 8'hB0);
    peek(9'h03F, 8'hB1, "R3 slot 15");
    peek(9'h030, 8'hB2, "R3 wrapped to slot 0");
    peek(9'h040, 0, "R3 no spill to next page");

    // R4: 18 bytes
    send(9'h050, 18, 8'hC0);
    peek(9'h050, 8'hD0, "R4 slot 0 overwritten");
    peek(9'h051, 8'hD1, "R4 slot 1 overwritten");
    peek(9'h052, 8'hC2, "R4 slot 2 kept");
    peek(9'h05F, 8'hCF, "R4 slot 15");

    // R5: single byte
    send(9'h1FF, 1, 8'h5A);
    peek(9'h1FF, 8'h5A, "R5 single byte");
    peek(9'h1FE, 0, "R5 neighbour unchanged");

    // R6 upper ranges
    prot_code = 3'b001;
    send(9'h180, 1, 8'h11);
    send(9'h17F, 1, 8'h22);
    peek(9'h180, 0, "R6 code001 blocked");
    peek(9'h17F, 8'h22, "R6 code001 below open");
    prot_code = 3'b010;
    send(9'h100, 1, 8'h33);
    send(9'h0FF, 1, 8'h44);
    peek(9'h100, 0, "R6 code010 blocked");
    peek(9'h0FF, 8'h44, "R6 code010 below open");

    // R7 lower ranges
    prot_code = 3'b100;
    send(9'h03F, 1, 8'h55);
    send(9'h040, 1, 8'h66);
    peek(9'h03F, 8'hB1, "R7 code100 blocked");
    peek(9'h040, 8'h66, "R7 code100 above open");
    prot_code = 3'b101;
    send(9'h07F, 1, 8'h77);
    send(9'h080, 1, 8'h88);
    peek(9'h07F, 0, "R7 code101 blocked");
    peek(9'h080, 8'h88, "R7 code101 above open");
    prot_code = 3'b110;
    send(9'h0FF, 1, 8'h99);
    send(9'h100, 1, 8'hAA);
    peek(9'h0FF, 8'h44, "R7 code110 blocked");
    peek(9'h100, 8'hAA, "R7 code110 above open");

    // R8, R9: full protection
    prot_code = 3'b011;
    send(9'h000, 4, 8'hE0);
    peek(9'h000, 0, "R8 code011 blocked");
    prot_code = 3'b111;
    send(9'h1FF, 1, 8'hEE);
    peek(9'h1FF, 8'h5A, "R9 code111 keeps old value");
    prot_code = 3'b000;
    send(9'h000, 1, 8'hE5);
    peek(9'h000, 8'hE5, "R8 code000 open");

    // R11: beats offered during commit are refused
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 9'h0A0; wr_data = 8'h71; wr_last = 1'b1;
    @(negedge clk);
    check("R10 busy after last", busy, 1);
    wr_addr = 9'h0B0; wr_data = 8'h72;
    repeat (5) @(negedge clk);
    check("R11 ready low in commit", wr_ready, 0);
    wr_valid = 1'b0; wr_last = 1'b0;
    while (busy) @(negedge clk);
    peek(9'h0A0, 8'h71, "R11 accepted byte");
    peek(9'h0B0, 0, "R11 refused beat not stored");

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule